// File: doc/BRIEF.md
# Parallel-Access Shift Register with J-K Serial Entry

This block is a rising-edge register of configurable width (four stages by default) that either moves its contents one place toward the highest-index stage or captures a full parallel word, depending on a single mode pin. In shift mode, the lowest stage is not loaded from a plain serial bit. It is fed by a J-K style pair, in which the second input is active-low. With this pair the entry stage can be cleared, set, held or toggled. Wiring the two inputs together makes them an ordinary serial data input.

Every stage drives a true output, and an extra output carries the inverse of the highest stage. An active-low master reset clears the register at once, without waiting for a clock edge. The block has no dedicated left-shift mode. To shift toward stage 0, wire each output `q[n]` to parallel input `par_d[n-1]` and keep the block in load mode.

All pins are plain control or data levels sampled at the clock edge. No handshake is involved: the register accepts a word or a shift step on every edge.

Top module: `psr_jk_shifter`

## Requirements
- R1: With `shift_en`=1, on each rising edge stage n (n ≥ 1) takes the value stage n-1 held before the edge.
- R2: With `shift_en`=0, on each rising edge every stage n takes `par_d[n]`.
- R3: In shift mode with `j_in` equal to `k_n_in`, stage 0 takes the value of `j_in` (J=0,K=0 gives 0; J=1,K=1 gives 1).
- R4: In shift mode with `j_in`=0 and `k_n_in`=1, stage 0 keeps its previous value.
- R5: In shift mode with `j_in`=1 and `k_n_in`=0, stage 0 takes the inverse of its previous value.
- R6: In load mode, `j_in` and `k_n_in` have no effect: stage 0 takes `par_d[0]` for all four J/K combinations.
- R7: While `rst_n` is 0, all stages read 0. The clearing takes effect as soon as `rst_n` falls, mid-cycle included, and clock edges that arrive while it is low are ignored.
- R8: `q_last_n` always equals the inverse of `q[WIDTH-1]`, including during reset, when it reads 1.
- R9: If `par_d[n-1]` is driven from `q[n]` and `par_d[WIDTH-1]` from an external bit, holding `shift_en`=0 moves the contents one place toward stage 0 on each edge, with the external bit entering at the top stage.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low master reset |
| shift_en | input | 1 | 1 = shift toward the top stage, 0 = parallel load |
| j_in | input | 1 | J input of the entry stage |
| k_n_in | input | 1 | Active-low K input of the entry stage |
| par_d | input | WIDTH | Parallel load word, bit n goes to stage n |
| q | output | WIDTH | True outputs of all stages |
| q_last_n | output | 1 | Inverse of the highest stage |

## Verification
Two things can happen in the same cycle. First, on every shift edge the J-K update of stage 0 and the move of all other stages happen together. The bench sweeps every 4-bit starting word against each J/K pair and compares the whole word with a value computed arithmetically, so a fault in either the entry logic or the move shows up. Second, the asynchronous reset can fall partway through a cycle in which a load has already been set up. The bench drops `rst_n` between edges, checks the outputs before the next edge, then lets an edge arrive while reset is still low and checks that the pending load is discarded.

// File: rtl/psr_pkg.sv
package psr_pkg;

  typedef enum logic [1:0] {
    JK_CLEAR  = 2'b00,
    JK_HOLD   = 2'b01,
    JK_TOGGLE = 2'b10,
    JK_SET    = 2'b11
  } jk_action_e;

  function automatic jk_action_e jk_decode(input logic j, input logic k_n);
    return jk_action_e'({j, k_n});
  endfunction

endpackage

// File: rtl/psr_jk_entry.sv
module psr_jk_entry
  import psr_pkg::*;
(
  input  logic j_in,
  input  logic k_n_in,
  input  logic cur_bit,
  output logic next_bit
);

  jk_action_e act;

  always_comb begin
    act = jk_decode(j_in, k_n_in);
    unique case (act)
      JK_CLEAR:  next_bit = 1'b0;
      JK_SET:    next_bit = 1'b1;
      JK_HOLD:   next_bit = cur_bit;
      JK_TOGGLE: next_bit = ~cur_bit;
      default:   next_bit = cur_bit;
    endcase
  end

endmodule

// File: rtl/psr_next_mux.sv
module psr_next_mux #(
  parameter int WIDTH = 4
) (
  input  logic             shift_en,
  input  logic             entry_bit,
  input  logic [WIDTH-1:0] cur_q,
  input  logic [WIDTH-1:0] par_d,
  output logic [WIDTH-1:0] next_q
);

  localparam int TOP = WIDTH - 1;

  always_comb next_q[0] = shift_en ? entry_bit : par_d[0];

  for (genvar g = 1; g <= TOP; g++) begin : g_stage
    always_comb next_q[g] = shift_en ? cur_q[g-1] : par_d[g];
  end

endmodule

// File: rtl/psr_jk_shifter.sv
module psr_jk_shifter #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_en,
  input  logic             j_in,
  input  logic             k_n_in,
  input  logic [WIDTH-1:0] par_d,
  output logic [WIDTH-1:0] q,
  output logic             q_last_n
);

  localparam int TOP = WIDTH - 1;

  logic [WIDTH-1:0] stage_q;
  logic [WIDTH-1:0] stage_nxt;
  logic             entry_nxt;

  psr_jk_entry u_entry (
    .j_in     (j_in),
    .k_n_in   (k_n_in),
    .cur_bit  (stage_q[0]),
    .next_bit (entry_nxt)
  );

  psr_next_mux #(.WIDTH(WIDTH)) u_mux (
    .shift_en  (shift_en),
    .entry_bit (entry_nxt),
    .cur_q     (stage_q),
    .par_d     (par_d),
    .next_q    (stage_nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= stage_nxt;
  end

  assign q        = stage_q;
  assign q_last_n = ~stage_q[TOP];

endmodule

// File: rtl/psr_jk_shifter_chk.sv
module psr_jk_shifter_chk #(
  parameter int WIDTH = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             shift_en,
  input logic             j_in,
  input logic             k_n_in,
  input logic [WIDTH-1:0] par_d,
  input logic [WIDTH-1:0] q
);

  assert_load_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> q == $past(par_d));

  assert_shift_move_R1: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> q[WIDTH-1:1] == $past(q[WIDTH-2:0]));

  assert_entry_follow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && (j_in == k_n_in)) |=> q[0] == $past(j_in));

  assert_entry_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && !j_in && k_n_in) |=> $stable(q[0]));

  assert_entry_toggle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && j_in && !k_n_in) |=> q[0] != $past(q[0]));

endmodule

bind psr_jk_shifter psr_jk_shifter_chk #(.WIDTH(WIDTH)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .shift_en (shift_en),
  .j_in     (j_in),
  .k_n_in   (k_n_in),
  .par_d    (par_d),
  .q        (q)
);

// File: tb/psr_jk_shifter_tb.sv
module psr_jk_shifter_tb;

  localparam int W = 4;
  localparam int MASK = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         shift_en = 1'b0;
  logic         j_in = 1'b0;
  logic         k_n_in = 1'b0;
  logic [W-1:0] par_d = '0;
  logic [W-1:0] q;
  logic         q_last_n;

  int n_cmp = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  psr_jk_shifter #(.WIDTH(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .j_in(j_in),
    .k_n_in(k_n_in), .par_d(par_d), .q(q), .q_last_n(q_last_n)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_word(input string tag, input int exp);
    chk(tag, int'(q), exp);
    chk({tag, " R8"}, int'(q_last_n), ((exp >> (W-1)) & 1) ^ 1);
  endtask

  // drive at negedge, one rising edge, sample at the following negedge
  task automatic step(input logic se, input logic j, input logic k, input int d);
    shift_en = se; j_in = j; k_n_in = k; par_d = W'(d);
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic int entry_exp(input int j, input int k, input int b);
    if (j == k) return j;
    if (j == 0) return b;
    return b ^ 1;
  endfunction

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    chk_word("R7 reset state", 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 + R6: every word with every J/K pair in load mode
    for (int s = 0; s <= MASK; s++)
      for (int jk = 0; jk < 4; jk++) begin
        step(1'b0, jk[1], jk[0], s);
        chk_word("R2/R6 load", s);
      end

    // R1 R3 R4 R5: every start word, every J/K pair, one shift
    for (int s = 0; s <= MASK; s++)
      for (int jk = 0; jk < 4; jk++) begin
        int e;
        step(1'b0, 1'b0, 1'b0, s);
        step(1'b1, jk[1], jk[0], 0);
        e = ((s << 1) & MASK) | entry_exp(jk[1], jk[0], s & 1);
        if (jk[1] == jk[0])   chk_word("R1/R3 shift follow", e);
        else if (jk[1] == 0)  chk_word("R1/R4 shift hold", e);
        else                  chk_word("R1/R5 shift toggle", e);
      end

    // R5: repeated toggles over several edges, plus R1 propagation
    step(1'b0, 1'b0, 1'b0, 0);
    begin
      int m = 0;
      for (int i = 0; i < 6; i++) begin
        step(1'b1, 1'b1, 1'b0, 0);
        m = ((m << 1) & MASK) | ((m & 1) ^ 1);
        chk_word("R5 toggle chain", m);
      end
    end

    // R9: external left-shift wiring in load mode
    step(1'b0, 1'b0, 1'b0, 4'b1011);
    begin
      int m = 4'b1011;
      for (int i = 0; i < 6; i++) begin
        int sin = i & 1;
        step(1'b0, 1'b1, 1'b0, (sin << (W-1)) | (int'(q) >> 1));
        m = (m >> 1) | (sin << (W-1));
        chk_word("R9 left shift", m);
      end
    end

    // R7: reset dropped mid-cycle with a load pending
    step(1'b0, 1'b0, 1'b0, MASK);
    chk_word("R7 preload", MASK);
    shift_en = 1'b0; par_d = W'(4'b0110);
    #5 rst_n = 1'b0;
    #2;
    chk_word("R7 async clear", 0);
    @(posedge clk);
    #3;
    chk_word("R7 edge during reset", 0);
    @(negedge clk);
    rst_n = 1'b1;
    step(1'b0, 1'b0, 1'b0, 4'b0110);
    chk_word("R7 after release", 4'b0110);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule